// File: doc/BRIEF.md
# Streaming byte-ECC syndrome generator and error classifier

This block sits on the receive side of a byte-oriented error-correcting code. It takes a 32-byte codeword one byte per accepted cycle: 28 information bytes first, then 4 check bytes. While the information bytes arrive, four accumulator lanes rebuild the check bytes using the same weighting as the encoder. Each lane multiplies by a power of the transition matrix of an 8-cell linear cellular automaton, using Horner's scheme. As each received check byte arrives, it is XORed with its rebuilt value to form one 8-bit syndrome.

Once the last check byte has been taken, a classifier marks each syndrome as zero or non-zero. From the four resulting flags it reports a class code. The code tells apart a clean word, damage confined to the check bytes, and damage that involves information bytes, which a downstream locator must resolve. Error location and correction are not done here. The syndromes and the class stay on the outputs until the next word overwrites them.

Top module: `byte_ecc_syndrome`

## Requirements
- R1: Syndrome j (j = 0..3) is the received check byte j XOR the check byte j rebuilt from the received information bytes. It appears on `syndromes[8j+7:8j]`.
- R2: Rebuilt check byte a is the XOR over k = 0..27 of T^(a*(28-k)) applied to information byte k. T is one step of an 8-cell automaton with bit i as cell i and zero boundaries. In that step, next[i] = cell[i-1] ^ cell[i+1], plus cell[i] itself on cells 0, 1, 3, 5 and 7.
- R3: A byte is taken only on a rising edge with `byte_valid` high. Bytes 0..27 of a word are information and bytes 28..31 are check bytes 0..3. Idle cycles inside a word have no effect on the result.
- R4: `result_valid` is high for exactly the one cycle after the edge that takes byte 31, and low at all other times.
- R5: When all four syndromes are zero, `err_class` is 0 (clean).
- R6: When exactly one syndrome is non-zero, `err_class` is 1 and `chk_pos` gives that syndrome's index. For every other class, `chk_pos` is 0.
- R7: When only syndromes 2 and 3 are non-zero, `err_class` is 2 (check bytes 2 and 3 damaged).
- R8: When syndrome 0 is zero and syndromes 1, 2 and 3 are all non-zero, `err_class` is 3 (two or more errors).
- R9: When all four syndromes are non-zero, `err_class` is 4 (information-byte damage, for the locator).
- R10: Any other zero/non-zero pattern gives `err_class` 5 (uncorrectable).
- R11: Syndromes, class and position hold their values until the next word's check bytes replace them. A new word may start on the cycle right after byte 31, with no idle cycle in between.
- R12: While `rst_n` is low, `result_valid`, `syndromes`, `err_class` and `chk_pos` are all 0, and the byte position returns to the start of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | `byte_in` carries the next codeword byte |
| byte_in | input | 8 | Codeword byte, information bytes first |
| result_valid | output | 1 | One-cycle pulse: results belong to the word just completed |
| syndromes | output | 32 | Four syndromes, syndrome j at bits 8j+7:8j |
| err_class | output | 3 | Error class code (0..5) |
| chk_pos | output | 2 | Index of the lone non-zero syndrome for class 1 |

## Verification
The bench goes after the weighting corners. Damage in byte 0 carries the highest matrix power, damage in byte 27 the lowest, and a lane that miscounted its exponent or its first-byte clear would give wrong syndromes at one or both ends. An information-byte error masked in syndrome 0 by an equal change to check byte 0 must give class 3, which a pattern table that lumped unlisted patterns together would report as class 4 or 5. Lone errors on each check byte test `chk_pos`, and two-check patterns outside the table must fall to class 5. Idle gaps, back-to-back words and a reset in mid-word check the byte counter: a design that counted idle cycles or failed to rewind would shift every later byte into the wrong lane.

// File: rtl/byte_ecc_pkg.sv
// Package: shared constants, class encoding and the cellular-automaton
// step used to weight information bytes.
// Assumes a byte is one automaton state (CA_W cells, bit i is cell i).
package byte_ecc_pkg;

    localparam int CA_W    = 8;
    localparam int NUM_SYN = 4;

    typedef logic [CA_W-1:0] cell_t;

    typedef enum logic [2:0] {
        CLS_CLEAN   = 3'd0,
        CLS_CHK_ONE = 3'd1,
        CLS_CHK_23  = 3'd2,
        CLS_MULTI   = 3'd3,
        CLS_INFO    = 3'd4,
        CLS_UNCORR  = 3'd5
    } err_class_e;

    // One automaton step with null boundaries; r150[i] adds cell i itself.
    function automatic cell_t ca_step(input cell_t s, input cell_t r150);
        cell_t nxt;
        cell_t left;
        cell_t right;
        left  = s << 1;
        right = s >> 1;
        nxt   = left ^ right ^ (r150 & s);
        return nxt;
    endfunction

    // Apply ca_step n times, n below NUM_SYN.
    function automatic cell_t ca_power(input cell_t s, input cell_t r150,
                                       input int unsigned n);
        cell_t v;
        v = s;
        for (int k = 0; k < NUM_SYN; k++) begin
            if (k < int'(n)) begin
                v = ca_step(v, r150);
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/byte_ecc_frame_ctr.sv
// Module: byte position counter for one codeword.
// Counts only accepted bytes, so idle cycles do not move the position.
// Wraps to zero after the last byte, so words may follow back to back.
module byte_ecc_frame_ctr #(
    parameter int FRAME_BYTES = 32,
    parameter int INFO_BYTES  = 28,
    parameter int IDX_W       = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    output logic [IDX_W-1:0] idx,
    output logic             first_en,
    output logic             info_en,
    output logic             last_en
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
    localparam logic [IDX_W-1:0] INFO_END = IDX_W'(INFO_BYTES);

    // Strobes for the byte currently on the input.
    always_comb begin
        first_en = byte_valid && (idx == '0);
        info_en  = byte_valid && (idx < INFO_END);
        last_en  = byte_valid && (idx == LAST_IDX);
    end

    // Advance the position on each accepted byte, wrapping after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (byte_valid) begin
            if (idx == LAST_IDX) begin
                idx <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/byte_ecc_syn_lane.sv
// Module: one syndrome lane.
// Accumulates acc = T^LANE * (acc ^ byte) over the information bytes
// (Horner form of the weighted sum). When its own check byte arrives,
// it latches the syndrome.
// Assumes first_en and step_en fall on the same byte at a word start.
module byte_ecc_syn_lane
    import byte_ecc_pkg::*;
#(
    parameter int    LANE      = 0,
    parameter cell_t RULE_MASK = 8'hAB
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_en,
    input  logic  first_en,
    input  logic  cap_en,
    input  cell_t din,
    output cell_t syn
);

    cell_t acc;
    cell_t acc_base;
    cell_t acc_next;

    // Next accumulator value: a new word starts from zero.
    always_comb begin
        acc_base = first_en ? '0 : acc;
        acc_next = ca_power(acc_base ^ din, RULE_MASK, LANE);
    end

    // Update the accumulator on information bytes; latch syndrome on own check byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            syn <= '0;
        end else begin
            if (step_en) begin
                acc <= acc_next;
            end
            if (cap_en) begin
                syn <= din ^ acc;
            end
        end
    end

endmodule

// File: rtl/byte_ecc_classify.sv
// Module: maps the zero/non-zero pattern of the four syndromes to a class.
// Purely combinational. Assumes exactly four syndromes.
module byte_ecc_classify
    import byte_ecc_pkg::*;
(
    input  cell_t      syn [NUM_SYN],
    output err_class_e cls,
    output logic [1:0] pos
);

    logic [NUM_SYN-1:0] nz;

    // Non-zero flag per syndrome by OR reduction.
    always_comb begin
        for (int j = 0; j < NUM_SYN; j++) begin
            nz[j] = |syn[j];
        end
    end

    // Pattern table: bit j of nz is syndrome j.
    always_comb begin
        pos = 2'd0;
        unique case (nz)
            4'b0000: cls = CLS_CLEAN;
            4'b0001: cls = CLS_CHK_ONE;
            4'b0010: begin cls = CLS_CHK_ONE; pos = 2'd1; end
            4'b0100: begin cls = CLS_CHK_ONE; pos = 2'd2; end
            4'b1000: begin cls = CLS_CHK_ONE; pos = 2'd3; end
            4'b1100: cls = CLS_CHK_23;
            4'b1110: cls = CLS_MULTI;
            4'b1111: cls = CLS_INFO;
            default: cls = CLS_UNCORR;
        endcase
    end

endmodule

// File: rtl/byte_ecc_syndrome.sv
// Module: top of the streaming syndrome generator and classifier.
// Takes one byte per valid cycle, information bytes first, then the check bytes.
// Results are valid in the cycle after the last check byte and are held afterwards.
module byte_ecc_syndrome
    import byte_ecc_pkg::*;
#(
    parameter int    INFO_BYTES = 28,
    parameter cell_t RULE_MASK  = 8'hAB
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_valid,
    input  logic [CA_W-1:0]         byte_in,
    output logic                    result_valid,
    output logic [NUM_SYN*CA_W-1:0] syndromes,
    output logic [2:0]              err_class,
    output logic [1:0]              chk_pos
);

    localparam int FRAME_BYTES = INFO_BYTES + NUM_SYN;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    logic [IDX_W-1:0]   idx;
    logic               first_en;
    logic               info_en;
    logic               last_en;
    logic [NUM_SYN-1:0] cap_en;
    cell_t              syn [NUM_SYN];
    err_class_e         cls;

    byte_ecc_frame_ctr #(
        .FRAME_BYTES (FRAME_BYTES),
        .INFO_BYTES  (INFO_BYTES),
        .IDX_W       (IDX_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .idx        (idx),
        .first_en   (first_en),
        .info_en    (info_en),
        .last_en    (last_en)
    );

    for (genvar g = 0; g < NUM_SYN; g++) begin : g_lane
        // Capture strobe for this lane's check byte.
        assign cap_en[g] = byte_valid && (idx == IDX_W'(INFO_BYTES + g));

        byte_ecc_syn_lane #(
            .LANE      (g),
            .RULE_MASK (RULE_MASK)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_en  (info_en),
            .first_en (first_en),
            .cap_en   (cap_en[g]),
            .din      (byte_in),
            .syn      (syn[g])
        );

        assign syndromes[g*CA_W +: CA_W] = syn[g];
    end

    byte_ecc_classify u_cls (
        .syn (syn),
        .cls (cls),
        .pos (chk_pos)
    );

    assign err_class = cls;

    // One-cycle result strobe after the last check byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
        end else begin
            result_valid <= last_en;
        end
    end

endmodule

// File: rtl/byte_ecc_syndrome_chk.sv
// Module: assertion checker bound to byte_ecc_syndrome.
// Watches the ports only.
module byte_ecc_syndrome_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        byte_valid,
    input logic        result_valid,
    input logic [31:0] syndromes,
    input logic [2:0]  err_class,
    input logic [1:0]  chk_pos
);

    logic [3:0] nz;

    // Non-zero flags recovered from the syndrome port.
    always_comb begin
        for (int j = 0; j < 4; j++) begin
            nz[j] = |syndromes[j*8 +: 8];
        end
    end

    // R4
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R4
    valid_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(byte_valid));

    // R5
    clean_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nz == 4'b0000) |-> (err_class == 3'd0));

    // R6
    single_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_class == 3'd1) |-> ($countones(nz) == 1 && nz[chk_pos]));

    // R8
    multi_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_class == 3'd3) |-> (nz == 4'b1110));

    // R9
    info_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_class == 3'd4) |-> (nz == 4'b1111));

    // R11
    hold_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(syndromes));

endmodule

bind byte_ecc_syndrome byte_ecc_syndrome_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid   (byte_valid),
    .result_valid (result_valid),
    .syndromes    (syndromes),
    .err_class    (err_class),
    .chk_pos      (chk_pos)
);

// File: tb/byte_ecc_syndrome_test.sv
module byte_ecc_syndrome_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        result_valid;
    logic [31:0] syndromes;
    logic [2:0]  err_class;
    logic [1:0]  chk_pos;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  frm [32];
    logic [31:0] exp_syn;
    logic [2:0]  exp_cls;
    logic [1:0]  exp_pos;

    always #4 clk = ~clk;

    byte_ecc_syndrome uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid   (byte_valid),
        .byte_in      (byte_in),
        .result_valid (result_valid),
        .syndromes    (syndromes),
        .err_class    (err_class),
        .chk_pos      (chk_pos)
    );

    // Corruption vectors: {posA[5:0], maskA[7:0], posB[5:0], maskB[7:0]}; pos 63 = none.
    localparam int NVEC = 12;
    localparam logic [27:0] VEC [NVEC] = '{
        {6'd63, 8'h00, 6'd63, 8'h00},  // clean (R5)
        {6'd29, 8'h5A, 6'd63, 8'h00},  // check 1 alone (R6)
        {6'd28, 8'h01, 6'd63, 8'h00},  // check 0 alone (R6)
        {6'd31, 8'h80, 6'd63, 8'h00},  // check 3 alone (R6)
        {6'd30, 8'h33, 6'd31, 8'h0F},  // checks 2 and 3 (R7)
        {6'd0,  8'hFF, 6'd63, 8'h00},  // first info byte (R2, R9)
        {6'd27, 8'h10, 6'd63, 8'h00},  // last info byte (R2, R9)
        {6'd13, 8'h21, 6'd5,  8'h84},  // two info bytes (R1)
        {6'd28, 8'h11, 6'd29, 8'h22},  // checks 0 and 1 (R10)
        {6'd10, 8'h3C, 6'd28, 8'h3C},  // info masked in S0 (R8)
        {6'd30, 8'h40, 6'd63, 8'h00},  // check 2 alone (R6)
        {6'd28, 8'h07, 6'd30, 8'h09}   // checks 0 and 2 (R10)
    };

    // Reference automaton step written from the rule list.
    function automatic logic [7:0] ref_step(input logic [7:0] s);
        int rule [8] = '{150, 150, 90, 150, 90, 150, 90, 150};
        logic [7:0] n;
        for (int i = 0; i < 8; i++) begin
            n[i] = 1'b0;
            if (i > 0) n[i] = n[i] ^ s[i-1];
            if (i < 7) n[i] = n[i] ^ s[i+1];
            if (rule[i] == 150) n[i] = n[i] ^ s[i];
        end
        return n;
    endfunction

    // Closed-form check byte a over frm[0..27].
    function automatic logic [7:0] ref_check(input int a);
        logic [7:0] acc = '0;
        for (int k = 0; k < 28; k++) begin
            logic [7:0] v = frm[k];
            for (int t = 0; t < a * (28 - k); t++) v = ref_step(v);
            acc = acc ^ v;
        end
        return acc;
    endfunction

    task automatic build_frame(input int seed, input logic [27:0] v);
        for (int k = 0; k < 28; k++) frm[k] = 8'(seed * 53 + k * 29 + k * k * 7 + 1);
        for (int a = 0; a < 4; a++) frm[28 + a] = ref_check(a);
        if (v[27:22] != 6'd63) frm[v[27:22]] = frm[v[27:22]] ^ v[21:14];
        if (v[13:8]  != 6'd63) frm[v[13:8]]  = frm[v[13:8]]  ^ v[7:0];
        for (int a = 0; a < 4; a++) exp_syn[a*8 +: 8] = ref_check(a) ^ frm[28 + a];
        begin
            logic [3:0] z;
            for (int a = 0; a < 4; a++) z[a] = |exp_syn[a*8 +: 8];
            exp_pos = 2'd0;
            case (z)
                4'b0000: exp_cls = 3'd0;
                4'b0001: exp_cls = 3'd1;
                4'b0010: begin exp_cls = 3'd1; exp_pos = 2'd1; end
                4'b0100: begin exp_cls = 3'd1; exp_pos = 2'd2; end
                4'b1000: begin exp_cls = 3'd1; exp_pos = 2'd3; end
                4'b1100: exp_cls = 3'd2;
                4'b1110: exp_cls = 3'd3;
                4'b1111: exp_cls = 3'd4;
                default: exp_cls = 3'd5;
            endcase
        end
    endtask

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive the word; no_wait0 puts byte 0 in the current cycle.
    task automatic send_frame(input bit gaps, input bit no_wait0);
        for (int i = 0; i < 32; i++) begin
            if (gaps && (i % 7 == 3)) begin
                @(negedge clk);
                byte_valid = 1'b0;
            end
            if (!(no_wait0 && i == 0)) @(negedge clk);
            if (i == 16) check_eq("R4 no strobe mid-word", 32'(result_valid), 32'd0);
            byte_valid = 1'b1;
            byte_in    = frm[i];
        end
    endtask

    task automatic check_result(input string tag);
        check_eq({"R4 strobe ", tag}, 32'(result_valid), 32'd1);
        check_eq({"R1 R2 syndromes ", tag}, syndromes, exp_syn);
        check_eq({"class R5-style table ", tag}, 32'(err_class), 32'(exp_cls));
        check_eq({"R6 chk_pos ", tag}, 32'(chk_pos), 32'(exp_pos));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        check_eq("R12 result_valid in reset", 32'(result_valid), 32'd0);
        check_eq("R12 syndromes in reset", syndromes, 32'd0);
        check_eq("R12 class in reset", 32'(err_class), 32'd0);
        check_eq("R12 pos in reset", 32'(chk_pos), 32'd0);
        rst_n = 1'b1;

        // Table walk over the vectors (R1 R2 R5 R6 R7 R8 R9 R10)
        for (int n = 0; n < NVEC; n++) begin
            build_frame(n + 3, VEC[n]);
            send_frame(1'b0, 1'b0);
            @(negedge clk);
            byte_valid = 1'b0;
            check_result($sformatf("vec%0d", n));
            @(negedge clk);
            check_eq("R4 strobe one cycle", 32'(result_valid), 32'd0);
            check_eq("R11 syndromes held", syndromes, exp_syn);
        end

        // R3: idle gaps inside a word
        build_frame(41, VEC[6]);
        send_frame(1'b1, 1'b0);
        @(negedge clk);
        byte_valid = 1'b0;
        check_result("R3 gapped");

        // R11: back-to-back words
        build_frame(57, VEC[1]);
        send_frame(1'b0, 1'b0);
        @(negedge clk);
        check_result("R11 word A");
        build_frame(58, VEC[9]);
        send_frame(1'b0, 1'b1);
        @(negedge clk);
        byte_valid = 1'b0;
        check_result("R11 word B");

        // R12: reset mid-word rewinds position
        build_frame(77, VEC[4]);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_in    = frm[i];
        end
        @(negedge clk);
        byte_valid = 1'b0;
        rst_n      = 1'b0;
        @(negedge clk);
        check_eq("R12 syndromes cleared", syndromes, 32'd0);
        rst_n = 1'b1;
        send_frame(1'b0, 1'b0);
        @(negedge clk);
        byte_valid = 1'b0;
        check_result("R12 after mid-word reset");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule